// File: doc/BRIEF.md
# Free-Running 16-bit Timer with Tear-Free Byte Reads

This block is a 16-bit up-counter that never stops except under a halt request. An 8-bit CPU reads it one byte at a time. Reading the upper byte saves the lower byte in a holding register, so the next lower-byte read returns a value that matches the upper byte already taken. The counter has two address pairs that read the same count. One pair takes part in clearing the overflow flag and the other pair never affects it. Software can therefore sample elapsed time at any moment without losing a pending overflow.

A rollover from FFFFh to 0000h sets a sticky overflow flag. The interrupt line is the flag gated by an enable bit and by the CPU's global interrupt mask, so a masked overflow stays pending until both gates open. The flag clears only after a two-step sequence: a status read that sees the flag set, then any access to the main low-byte address. The count rate is the CPU clock divided by 2, 4 or 8, or one count per selected edge of an external pin. That pin is sampled on falling CPU clock edges.

Top module: `freerun_timer16`

## Requirements
- R1: After reset the count is FFFCh, the status byte reads 00h, control A reads 00h, control B reads 00h (divide by 4, falling edge), and `irq` is low.
- R2: Control B bits [1:0] select the count rate: 00 gives one count per 4 CPU cycles, 01 one per 2, 10 one per 8, and 11 selects the external pin. Across any run of 8k unhalted cycles the count advances by exactly 8k divided by the ratio, and it only ever steps by +1.
- R3: A read of the main high byte (address 3) while no snapshot is held copies the live low byte into a buffer. The next low-byte read (address 4 or 6) returns that buffer and ends the sequence. Repeated high-byte reads before then leave the buffer unchanged. A low-byte read with no snapshot held returns the live low byte.
- R4: The alternate high byte (address 5) and alternate low byte (address 6) take part in the snapshot in the same way as addresses 3 and 4, and both read the same count.
- R5: When the count rolls from FFFFh to 0000h, status bit 7 (overflow flag) becomes 1. It is not set before the rollover.
- R6: `irq` is high exactly when the overflow flag is set, control A bit 7 (interrupt enable) is 1 and `cpu_imask` is 0. A flag that was set while it was gated drives `irq` as soon as both gates open.
- R7: The overflow flag clears only when a status read (address 2) that sees the flag set is followed by a read of the main low byte (address 4). Reads and writes of address 6 neither clear the flag nor cancel the armed step.
- R8: A main low-byte access with no preceding status read that saw the flag set leaves the flag set.
- R9: A write to address 4 completes the clear step in the same way as a read.
- R10: While `halt` is high the count and the prescaler hold their values. When `halt` falls, counting resumes from the held value.
- R11: In external mode (control B bits [1:0] = 11), control B bit 2 = 1 advances the count once per rising edge of `ext_clk` and bit 2 = 0 once per falling edge. The pin passes through two flops clocked on the falling CPU clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Freezes the counter and prescaler while high |
| cpu_imask | input | 1 | CPU global interrupt mask, 1 = masked |
| ext_clk | input | 1 | External count pin |
| addr | input | 3 | Register address: 0 ctrl A, 1 ctrl B, 2 status, 3 high, 4 low, 5 alt high, 6 alt low |
| rd | input | 1 | Single-cycle read strobe |
| wr | input | 1 | Single-cycle write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| irq | output | 1 | Overflow interrupt request |

## Verification
The in-module assertions check on every cycle that the count steps by at most one and holds under `halt`, that a rollover sets the flag, and that the flag stays set through any cycle without a main low-byte access. They also check that the snapshot buffer stays fixed while a sequence is open. Only the bench scenarios can show the rest: the exact advance per clock ratio, the ordering of the two-step clear, pending interrupt release, the value returned across a split read, and the edge polarity of the external pin.

// File: rtl/freerun_timer16.sv
`timescale 1ns/1ps
module freerun_timer16 #(
  parameter logic [15:0] CNT_RESET = 16'hFFFC,
  parameter int          AW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic          cpu_imask,
  input  logic          ext_clk,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTLA = AW'(0);
  localparam logic [AW-1:0] A_CTLB = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);
  localparam logic [AW-1:0] A_HI   = AW'(3);
  localparam logic [AW-1:0] A_LO   = AW'(4);
  localparam logic [AW-1:0] A_AHI  = AW'(5);
  localparam logic [AW-1:0] A_ALO  = AW'(6);

  logic [15:0] cnt;
  logic [7:0]  lo_buf;
  logic        lo_lock, ovf, clr_armed, ovf_ie, edge_rise;
  logic [1:0]  csel;
  logic [2:0]  pre;
  logic        ext_s1, ext_s2, ext_s3;
  logic        ext_pulse, tick, cnt_en;
  logic        hi_rd, lo_rd, main_lo, stat_rd;
  logic        unused_wbits;

  assign unused_wbits = ^wdata[6:3];

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_s1 <= 1'b0;
      ext_s2 <= 1'b0;
    end else begin
      ext_s1 <= ext_clk;
      ext_s2 <= ext_s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ext_s3 <= 1'b0;
    else        ext_s3 <= ext_s2;

  assign ext_pulse = edge_rise ? (ext_s2 & ~ext_s3) : (~ext_s2 & ext_s3);

  always_comb
    case (csel)
      2'b00:   tick = (pre[1:0] == 2'b11);
      2'b01:   tick = pre[0];
      2'b10:   tick = (pre == 3'b111);
      default: tick = ext_pulse;
    endcase

  assign cnt_en  = tick & ~halt;
  assign hi_rd   = rd & ((addr == A_HI) | (addr == A_AHI));
  assign lo_rd   = rd & ((addr == A_LO) | (addr == A_ALO));
  assign main_lo = (rd | wr) & (addr == A_LO);
  assign stat_rd = rd & (addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt       <= CNT_RESET;
      pre       <= '0;
      lo_buf    <= '0;
      lo_lock   <= 1'b0;
      ovf       <= 1'b0;
      clr_armed <= 1'b0;
      ovf_ie    <= 1'b0;
      csel      <= 2'b00;
      edge_rise <= 1'b0;
    end else begin
      if (!halt)  pre <= pre + 3'd1;
      if (cnt_en) cnt <= cnt + 16'd1;

      if (hi_rd && !lo_lock) begin
        lo_buf  <= cnt[7:0];
        lo_lock <= 1'b1;
      end else if (lo_rd) begin
        lo_lock <= 1'b0;
      end

      if (stat_rd && ovf) clr_armed <= 1'b1;
      if (main_lo && clr_armed) begin
        ovf       <= 1'b0;
        clr_armed <= 1'b0;
      end
      if (cnt_en && cnt == 16'hFFFF) ovf <= 1'b1;

      if (wr && addr == A_CTLA) ovf_ie <= wdata[7];
      if (wr && addr == A_CTLB) begin
        csel      <= wdata[1:0];
        edge_rise <= wdata[2];
      end
    end

  always_comb
    case (addr)
      A_CTLA:      rdata = {ovf_ie, 7'b0};
      A_CTLB:      rdata = {5'b0, edge_rise, csel};
      A_STAT:      rdata = {ovf, 7'b0};
      A_HI, A_AHI: rdata = cnt[15:8];
      A_LO, A_ALO: rdata = lo_lock ? lo_buf : cnt[7:0];
      default:     rdata = 8'h00;
    endcase

  assign irq = ovf & ovf_ie & ~cpu_imask;

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 16'd1));

  assert_halt_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> cnt == $past(cnt));

  assert_rollover_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 16'hFFFF && !halt && tick) |=> (ovf && cnt == 16'h0000));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !main_lo) |=> ovf);

  assert_buf_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_lock && !lo_rd) |=> (lo_lock && $stable(lo_buf)));

  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf && !cpu_imask));
endmodule

// File: tb/freerun_timer16_tb_top.sv
`timescale 1ns/1ps
module freerun_timer16_tb_top;
  localparam int CLK_P = 10;
  localparam logic [2:0] A_CTLA = 3'd0, A_CTLB = 3'd1, A_STAT = 3'd2,
                         A_HI = 3'd3, A_LO = 3'd4, A_AHI = 3'd5, A_ALO = 3'd6;
  localparam int         NV = 5;
  localparam logic [1:0] VSEL  [NV] = '{2'b01, 2'b00, 2'b10, 2'b01, 2'b10};
  localparam int         VCYC  [NV] = '{16, 32, 24, 40, 64};

  logic clk = 1'b0, rst_n = 1'b0, halt = 1'b1, cpu_imask = 1'b0, ext_clk = 1'b0;
  logic [2:0] addr = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  freerun_timer16 dut_i (.clk(clk), .rst_n(rst_n), .halt(halt), .cpu_imask(cpu_imask),
    .ext_clk(ext_clk), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #5 d = rdata;
    @(posedge clk); #2 rd = 1'b0;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #2 wr = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic run(input int n);
    halt = 1'b0;
    wait_cyc(n);
    halt = 1'b1;
  endtask

  task automatic read_alt(output logic [15:0] v);
    logic [7:0] h, l;
    bus_rd(A_AHI, h);
    bus_rd(A_ALO, l);
    v = {h, l};
  endtask

  task automatic do_reset();
    halt = 1'b1; rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
  endtask

  function automatic int ratio(input logic [1:0] s);
    case (s)
      2'b00:   return 4;
      2'b01:   return 2;
      default: return 8;
    endcase
  endfunction

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v0, v1;
    logic [7:0]  d, h;
    wait_cyc(2);
    do_reset();

    // R1 reset state
    read_alt(v0);                   chk("R1 count", v0, 16'hFFFC);
    bus_rd(A_STAT, d);              chk("R1 status", {8'h0, d}, 16'h0000);
    bus_rd(A_CTLA, d);              chk("R1 ctrlA", {8'h0, d}, 16'h0000);
    bus_rd(A_CTLB, d);              chk("R1 ctrlB", {8'h0, d}, 16'h0000);
    chk("R1 irq", {15'h0, irq}, 16'h0);

    // R5 rollover, divide-by-2 from prescaler phase 0
    bus_wr(A_CTLB, 8'h01);
    run(6);
    read_alt(v0);                   chk("R5 before wrap count", v0, 16'hFFFF);
    bus_rd(A_ALO, d);
    chk("R6 no irq before wrap", {15'h0, irq}, 16'h0);
    run(2);
    read_alt(v0);                   chk("R5 wrap count", v0, 16'h0000);

    // R6 pending interrupt
    chk("R6 irq gated by enable", {15'h0, irq}, 16'h0);
    bus_wr(A_CTLA, 8'h80); #1;
    chk("R6 irq released", {15'h0, irq}, 16'h1);
    cpu_imask = 1'b1; #1;
    chk("R6 irq masked", {15'h0, irq}, 16'h0);
    cpu_imask = 1'b0; #1;
    chk("R6 irq unmasked", {15'h0, irq}, 16'h1);

    // R8 main low access without status read
    bus_rd(A_LO, d);
    bus_rd(A_STAT, d);              chk("R8 flag kept", {8'h0, d}, 16'h0080);
    // R7 alternate low accesses do not clear, even when armed
    bus_rd(A_ALO, d);
    bus_wr(A_ALO, 8'h00);
    bus_rd(A_STAT, d);              chk("R7 alt keeps flag", {8'h0, d}, 16'h0080);
    chk("R7 irq still high", {15'h0, irq}, 16'h1);
    bus_rd(A_LO, d);
    bus_rd(A_STAT, d);              chk("R7 cleared", {8'h0, d}, 16'h0000);
    chk("R7 irq low", {15'h0, irq}, 16'h0);

    // R9 write path completes the clear
    do_reset();
    bus_wr(A_CTLB, 8'h01);
    run(8);
    bus_rd(A_STAT, d);              chk("R9 flag set", {8'h0, d}, 16'h0080);
    bus_wr(A_LO, 8'h55);
    bus_rd(A_STAT, d);              chk("R9 cleared by write", {8'h0, d}, 16'h0000);

    // R2 rate table
    for (int i = 0; i < NV; i++) begin
      bus_wr(A_CTLB, {6'b0, VSEL[i]});
      read_alt(v0);
      run(VCYC[i]);
      read_alt(v1);
      chk($sformatf("R2 vector %0d delta", i), v1 - v0, 16'(VCYC[i] / ratio(VSEL[i])));
    end

    // R3 snapshot on main pair
    bus_wr(A_CTLB, 8'h01);
    read_alt(v0);
    bus_rd(A_HI, h);                chk("R3 high byte", {8'h0, h}, {8'h0, v0[15:8]});
    run(8);
    bus_rd(A_HI, h);
    bus_rd(A_LO, d);                chk("R3 buffered low", {8'h0, d}, {8'h0, v0[7:0]});
    bus_rd(A_LO, d);                chk("R3 live low", {8'h0, d}, {8'h0, v0[7:0] + 8'd4});

    // R4 snapshot on alternate pair
    read_alt(v0);
    bus_rd(A_AHI, h);
    run(16);
    bus_rd(A_AHI, h);
    bus_rd(A_ALO, d);               chk("R4 buffered low", {8'h0, d}, {8'h0, v0[7:0]});
    bus_rd(A_ALO, d);               chk("R4 live low", {8'h0, d}, {8'h0, v0[7:0] + 8'd8});

    // R10 halt freezes, then resumes
    read_alt(v0);
    wait_cyc(20);
    read_alt(v1);                   chk("R10 frozen", v1, v0);
    run(8);
    read_alt(v1);                   chk("R10 resume", v1, v0 + 16'd4);

    // R11 external, rising edges (3 rises, 2 falls)
    bus_wr(A_CTLB, 8'h07);
    read_alt(v0);
    halt = 1'b0;
    ext_clk = 1'b1; wait_cyc(8);
    ext_clk = 1'b0; wait_cyc(8);
    ext_clk = 1'b1; wait_cyc(8);
    ext_clk = 1'b0; wait_cyc(8);
    ext_clk = 1'b1; wait_cyc(8);
    halt = 1'b1;
    read_alt(v1);                   chk("R11 rising count", v1 - v0, 16'd3);

    // R11 external, falling edges (2 falls, 1 rise)
    bus_wr(A_CTLB, 8'h03);
    read_alt(v0);
    halt = 1'b0;
    ext_clk = 1'b0; wait_cyc(8);
    ext_clk = 1'b1; wait_cyc(8);
    ext_clk = 1'b0; wait_cyc(8);
    halt = 1'b1;
    read_alt(v1);                   chk("R11 falling count", v1 - v0, 16'd2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule